// File: doc/BRIEF.md
# PCI Burst Initiator Sequencer

This block is the initiator half of a 32-bit PCI-style bus. It assumes the bus is already granted. A local agent hands it one request at a time. A request holds a start address, a direction and a word count. The block then runs the whole bus transaction: an address phase, then one or more data phases, then an idle turnaround cycle. It drives the framing, initiator-ready, address/data and command/byte-enable lines. It samples the target's device-select, target-ready and stop lines.

Write words come in on a valid/ready stream with per-word byte enables. The block pulls a word only when a data-phase slot is free, so a slow producer adds initiator wait states on the bus. Read words leave on a valid/ready stream through a small buffer. When the buffer could overflow, the block holds initiator-ready low, so a slow consumer also turns into bus wait states.

Each transaction ends in one of three ways:
- normal completion of every word;
- a target disconnect, when the target raises stop;
- a master-abort, when no target claims the address within a fixed window.

For each transaction the block reports one status pulse, which carries the outcome code and the number of words completed.

Top module: `pci_burst_initiator`

## Requirements
- R1: `req_ready` is high only while the bus is idle (framing and initiator-ready both low). An accepted request produces an address phase on the next cycle. In that cycle `bus_frame`=1, `bus_irdy`=0, `bus_ad_out` holds the address, `bus_cbe` holds command 4'h6 for a read or 4'h7 for a write, and both output enables are on.
- R2: `bus_frame` is raised only after at least one cycle in which `bus_frame` and `bus_irdy` were both low.
- R3: A data phase completes on a clock where `bus_irdy` and `bus_trdy` are both high. While `bus_irdy` is high and `bus_trdy` is low, `bus_irdy`, `bus_cbe` and the driven `bus_ad_out` stay unchanged. In data phases `bus_cbe` carries byte enables, where bit n=1 enables byte n. Reads use `req_be` for every phase.
- R4: `bus_frame` falls only while `bus_irdy` is high, in the cycle that starts the final data phase. `bus_irdy` drops on the clock after the final phase completes. A normal finish reports status 0 and a count equal to the request length.
- R5: A write word is taken when `wr_valid` and `wr_ready` are both high. It appears on `bus_ad_out`, with `wr_be` on `bus_cbe`, in the next cycle, and `bus_irdy` is high in that cycle. Words reach the bus in stream order.
- R6: Completed read words appear on `rd_data` in bus order. `rd_valid` and `rd_data` hold while `rd_ready` is low. `bus_irdy` is withheld so that the read buffer never drops a word.
- R7: The address phase is cycle A. If `bus_devsel` is not sampled high at any of the edges ending cycles A+1 to A+4, `bus_frame` is low from cycle A+5 on. `bus_irdy` follows one cycle later, and the outcome is status 2 with count 0. A device select first seen in cycle A+4 still claims the transaction.
- R8: A read that ends in master-abort delivers exactly one word of all-ones on the read stream.
- R9: When `bus_stop` is high, the current phase still completes if `bus_trdy` is also high. The transaction then ends with `bus_frame` falling while `bus_irdy` is high. The outcome is status 1, with a count equal to the completed phases.
- R10: After reset, `bus_frame`, `bus_irdy`, both output enables, `rd_valid` and `done_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AD_W | Start address |
| req_len | input | LEN_W | Word count, 1..MAX_BURST (0 treated as 1) |
| req_be | input | BE_W | Byte enables used for every read phase |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word taken |
| wr_data | input | AD_W | Write word |
| wr_be | input | BE_W | Byte enables for this write word |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Consumer takes read word |
| rd_data | output | AD_W | Read word |
| done_valid | output | 1 | One-cycle outcome pulse |
| done_status | output | 2 | 0 normal, 1 disconnect, 2 master-abort |
| done_count | output | LEN_W | Data phases completed |
| bus_frame | output | 1 | Framing, asserted high |
| bus_irdy | output | 1 | Initiator ready, asserted high |
| bus_ad_out | output | AD_W | Address/data driven value |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_cbe | output | BE_W | Command in address phase, byte enables in data phases |
| bus_cbe_oe | output | 1 | Drive enable for bus_cbe |
| bus_ad_in | input | AD_W | Address/data as seen on the bus (read data) |
| bus_devsel | input | 1 | Target claims the transaction |
| bus_trdy | input | 1 | Target ready |
| bus_stop | input | 1 | Target requests termination |

## Verification
Some bus rules hold on every cycle, and the assertions check them. A request is accepted only on an idle bus. Framing rises only after an idle cycle and never together with initiator-ready. Initiator-ready and the byte enables are held through wait states, and framing falls only under initiator-ready. An unclaimed transaction never keeps framing past the abort window. Read data is held under back-pressure.

Other behaviour needs the bench's target model, which claims addresses with varied device-select delays, random ready patterns and chosen disconnect points. Only those scenarios show the right word order and byte enables for writes, the right read values, the outcome code and count, the all-ones word on a read abort, and the exact cycle in which framing drops on an abort.

// File: rtl/pbi_pkg.sv
package pbi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_END,
    ST_TURN
  } seq_state_t;

  typedef enum logic [1:0] {
    END_OK    = 2'd0,
    END_DISC  = 2'd1,
    END_ABORT = 2'd2
  } end_code_t;

  localparam logic [3:0] CMD_MEM_RD = 4'h6;
  localparam logic [3:0] CMD_MEM_WR = 4'h7;

endpackage

// File: rtl/pbi_claim_timer.sv
// Counts data-phase cycles since the address phase and flags expiry
// when no target has claimed the transaction within ABORT_CLKS cycles.
module pbi_claim_timer #(
  parameter int ABORT_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic devsel,
  output logic expire,
  output logic claimed
);
  localparam int AGE_W = $clog2(ABORT_CLKS + 1);

  logic [AGE_W-1:0] age_q;
  logic             claimed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q     <= '0;
      claimed_q <= 1'b0;
    end else if (start) begin
      age_q     <= AGE_W'(1);
      claimed_q <= 1'b0;
    end else if (active) begin
      if (devsel) claimed_q <= 1'b1;
      if (age_q != AGE_W'(ABORT_CLKS)) age_q <= age_q + AGE_W'(1);
    end
  end

  assign expire  = active && !claimed_q && !devsel && (age_q == AGE_W'(ABORT_CLKS));
  assign claimed = claimed_q;
endmodule

// File: rtl/pbi_rd_buffer.sv
// Small ring buffer between bus read completions and the read stream.
module pbi_rd_buffer #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop_ready,
  output logic                         out_valid,
  output logic [W-1:0]                 out_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [$clog2(DEPTH+1)-1:0]   count_next
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign out_valid  = (cnt_q != '0);
  assign out_data   = mem_q[rd_ptr_q];
  assign pop        = out_valid && pop_ready;
  assign count      = cnt_q;
  assign count_next = cnt_q + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) begin
        mem_q[wr_ptr_q] <= push_data;
        wr_ptr_q        <= ptr_inc(wr_ptr_q);
      end
      if (pop) rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= count_next;
    end
  end
endmodule

// File: rtl/pci_burst_initiator.sv
module pci_burst_initiator
  import pbi_pkg::*;
#(
  parameter  int AD_W       = 32,
  parameter  int MAX_BURST  = 16,
  parameter  int ABORT_CLKS = 4,
  parameter  int RD_DEPTH   = 2,
  localparam int BE_W       = AD_W / 8,
  localparam int LEN_W      = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AD_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BE_W-1:0]   req_be,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AD_W-1:0]   wr_data,
  input  logic [BE_W-1:0]   wr_be,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [AD_W-1:0]   rd_data,
  output logic              done_valid,
  output logic [1:0]        done_status,
  output logic [LEN_W-1:0]  done_count,
  output logic              bus_frame,
  output logic              bus_irdy,
  output logic [AD_W-1:0]   bus_ad_out,
  output logic              bus_ad_oe,
  output logic [BE_W-1:0]   bus_cbe,
  output logic              bus_cbe_oe,
  input  logic [AD_W-1:0]   bus_ad_in,
  input  logic              bus_devsel,
  input  logic              bus_trdy,
  input  logic              bus_stop
);
  localparam int CW = $clog2(RD_DEPTH + 1);

  seq_state_t       state_q;
  end_code_t        code_q;
  logic             frame_q, irdy_q, ad_oe_q, cbe_oe_q, is_wr_q;
  logic [AD_W-1:0]  ad_q;
  logic [BE_W-1:0]  cbe_q, rd_be_q;
  logic [LEN_W-1:0] len_q, issued_q, done_cnt_q;

  logic in_data, xfer, stop_seen, last_done, expire, claimed;
  logic slot_open, more, space_ok, load, final_load;
  logic abort_beat, turn_hold, rd_push;
  logic [AD_W-1:0] rd_push_data;
  logic [CW-1:0]   rd_cnt, rd_cnt_next;

  pbi_claim_timer #(.ABORT_CLKS(ABORT_CLKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (state_q == ST_ADDR),
    .active  (in_data),
    .devsel  (bus_devsel),
    .expire  (expire),
    .claimed (claimed)
  );

  pbi_rd_buffer #(.W(AD_W), .DEPTH(RD_DEPTH)) u_rdbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (rd_push),
    .push_data  (rd_push_data),
    .pop_ready  (rd_ready),
    .out_valid  (rd_valid),
    .out_data   (rd_data),
    .count      (rd_cnt),
    .count_next (rd_cnt_next)
  );

  // Bus phase decode
  assign in_data    = (state_q == ST_DATA);
  assign xfer       = in_data && irdy_q && bus_trdy;
  assign stop_seen  = in_data && bus_stop && (bus_devsel || claimed);
  assign last_done  = xfer && !frame_q;

  // Next data-phase slot: free after the address phase, while no phase is
  // pending, or as the pending one completes; never while the burst ends.
  assign slot_open  = (state_q == ST_ADDR) ||
                      (in_data && (!irdy_q || xfer) && !(expire || stop_seen || last_done));
  assign more       = (issued_q < len_q);
  assign space_ok   = (rd_cnt_next < CW'(RD_DEPTH));
  assign load       = slot_open && more && (is_wr_q ? wr_valid : space_ok);
  assign final_load = load && ((issued_q + LEN_W'(1)) == len_q);
  assign wr_ready   = slot_open && more && is_wr_q;

  // Read buffer feed; an aborted read yields one all-ones word
  assign abort_beat   = (state_q == ST_TURN) && (code_q == END_ABORT) && !is_wr_q &&
                        (rd_cnt < CW'(RD_DEPTH));
  assign turn_hold    = (state_q == ST_TURN) && (code_q == END_ABORT) && !is_wr_q &&
                        !(rd_cnt < CW'(RD_DEPTH));
  assign rd_push      = (xfer && !is_wr_q) || abort_beat;
  assign rd_push_data = abort_beat ? {AD_W{1'b1}} : bus_ad_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      code_q     <= END_OK;
      frame_q    <= 1'b0;
      irdy_q     <= 1'b0;
      ad_oe_q    <= 1'b0;
      cbe_oe_q   <= 1'b0;
      is_wr_q    <= 1'b0;
      ad_q       <= '0;
      cbe_q      <= '0;
      rd_be_q    <= '0;
      len_q      <= '0;
      issued_q   <= '0;
      done_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q    <= ST_ADDR;
            frame_q    <= 1'b1;
            ad_q       <= req_addr;
            cbe_q      <= BE_W'(req_write ? CMD_MEM_WR : CMD_MEM_RD);
            ad_oe_q    <= 1'b1;
            cbe_oe_q   <= 1'b1;
            is_wr_q    <= req_write;
            rd_be_q    <= req_be;
            len_q      <= (req_len == '0) ? LEN_W'(1) : req_len;
            issued_q   <= '0;
            done_cnt_q <= '0;
            code_q     <= END_OK;
          end
        end
        ST_ADDR, ST_DATA: begin
          if (state_q == ST_ADDR) begin
            state_q <= ST_DATA;
            if (!is_wr_q) ad_oe_q <= 1'b0;
          end
          if (xfer) done_cnt_q <= done_cnt_q + LEN_W'(1);
          if (expire || stop_seen) begin
            code_q  <= expire ? END_ABORT : END_DISC;
            frame_q <= 1'b0;
            if (frame_q) begin
              state_q <= ST_END;
              irdy_q  <= 1'b1;
            end else begin
              state_q  <= ST_TURN;
              irdy_q   <= 1'b0;
              ad_oe_q  <= 1'b0;
              cbe_oe_q <= 1'b0;
            end
          end else if (last_done) begin
            state_q  <= ST_TURN;
            irdy_q   <= 1'b0;
            ad_oe_q  <= 1'b0;
            cbe_oe_q <= 1'b0;
          end else if (load) begin
            irdy_q   <= 1'b1;
            issued_q <= issued_q + LEN_W'(1);
            cbe_q    <= is_wr_q ? wr_be : rd_be_q;
            if (is_wr_q) ad_q <= wr_data;
            if (final_load) frame_q <= 1'b0;
          end else if (xfer) begin
            irdy_q <= 1'b0;
          end
        end
        ST_END: begin
          state_q  <= ST_TURN;
          irdy_q   <= 1'b0;
          ad_oe_q  <= 1'b0;
          cbe_oe_q <= 1'b0;
        end
        ST_TURN: begin
          if (!turn_hold) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign done_valid  = (state_q == ST_TURN) && !turn_hold;
  assign done_status = code_q;
  assign done_count  = done_cnt_q;
  assign bus_frame   = frame_q;
  assign bus_irdy    = irdy_q;
  assign bus_ad_out  = ad_q;
  assign bus_ad_oe   = ad_oe_q;
  assign bus_cbe     = cbe_q;
  assign bus_cbe_oe  = cbe_oe_q;
endmodule

// File: rtl/pbi_checker.sv
module pbi_checker #(
  parameter int AD_W       = 32,
  parameter int ABORT_CLKS = 4,
  parameter int BE_W       = AD_W / 8,
  parameter int LEN_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [AD_W-1:0]  rd_data,
  input logic             done_valid,
  input logic [1:0]       done_status,
  input logic [LEN_W-1:0] done_count,
  input logic             bus_frame,
  input logic             bus_irdy,
  input logic             bus_ad_oe,
  input logic             bus_cbe_oe,
  input logic [BE_W-1:0]  bus_cbe,
  input logic             bus_devsel,
  input logic             bus_trdy
);
  localparam int AGE_MAX = ABORT_CLKS + 1;
  localparam int AGW     = $clog2(AGE_MAX + 1);

  logic           prev_frame;
  logic           seen_sel;
  logic [AGW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_frame <= 1'b0;
      seen_sel   <= 1'b0;
      age        <= '0;
    end else begin
      prev_frame <= bus_frame;
      if (bus_frame && !prev_frame) begin
        age      <= AGW'(1);
        seen_sel <= 1'b0;
      end else if (age != '0) begin
        if (bus_devsel) seen_sel <= 1'b1;
        if (age != AGW'(AGE_MAX)) age <= age + AGW'(1);
      end
    end
  end

  // R1
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_frame && !bus_irdy));

  // R1
  addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_frame) |-> (!bus_irdy && bus_ad_oe && bus_cbe_oe));

  // R2
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_frame) |-> $past(!bus_frame && !bus_irdy));

  // R3
  irdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_irdy && bus_frame && !bus_trdy) |=> bus_irdy);

  // R3
  be_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_irdy && !bus_trdy) |=> $stable(bus_cbe));

  // R4
  frame_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_frame) |-> bus_irdy);

  // R4
  irdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_irdy && bus_trdy && !bus_frame) |=> !bus_irdy);

  // R5
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> bus_irdy);

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R7
  abort_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_frame && prev_frame && !seen_sel && (age > AGW'(ABORT_CLKS))));

  // R7
  abort_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_status == 2'd2) |-> (done_count == '0));
endmodule

bind pci_burst_initiator pbi_checker #(
  .AD_W(AD_W), .ABORT_CLKS(ABORT_CLKS), .BE_W(BE_W), .LEN_W(LEN_W)
) u_pbi_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .done_valid(done_valid), .done_status(done_status), .done_count(done_count),
  .bus_frame(bus_frame), .bus_irdy(bus_irdy), .bus_ad_oe(bus_ad_oe),
  .bus_cbe_oe(bus_cbe_oe), .bus_cbe(bus_cbe),
  .bus_devsel(bus_devsel), .bus_trdy(bus_trdy)
);

// File: tb/pci_burst_initiator_bench.sv
`timescale 1ns/1ps
module pci_burst_initiator_bench;
  localparam int MAXB   = 16;
  localparam int LEN_W  = 5;
  localparam int ABORTC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [3:0]  req_be = '0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic        done_valid;
  logic [1:0]  done_status;
  logic [LEN_W-1:0] done_count;
  logic        bus_frame, bus_irdy, bus_ad_oe, bus_cbe_oe;
  logic [31:0] bus_ad_out;
  logic [3:0]  bus_cbe;
  logic [31:0] bus_ad_in = '0;
  logic        bus_devsel = 1'b0, bus_trdy = 1'b0, bus_stop = 1'b0;

  always #4 clk = ~clk;

  pci_burst_initiator u_pci_burst_initiator (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_be(req_be),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_be(wr_be),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done_valid(done_valid), .done_status(done_status), .done_count(done_count),
    .bus_frame(bus_frame), .bus_irdy(bus_irdy), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_cbe(bus_cbe), .bus_cbe_oe(bus_cbe_oe),
    .bus_ad_in(bus_ad_in), .bus_devsel(bus_devsel), .bus_trdy(bus_trdy),
    .bus_stop(bus_stop)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %h exp %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rpat(input logic [31:0] a, input int i);
    return (a + 32'(4 * i)) ^ 32'h5A3C_0F96;
  endfunction

  // transaction plan
  bit          t_write, t_claim, exp_abort;
  logic [31:0] t_addr;
  int          t_len, t_dly, t_stopk;
  logic [3:0]  t_be;
  logic [31:0] wq [MAXB];
  logic [3:0]  wbe [MAXB];
  logic [31:0] wlog [MAXB];
  logic [3:0]  wlogbe [MAXB];
  bit          req_go = 0;

  // target model and stream state
  bit   in_txn = 0, stop_active = 0, pend_xfer = 0, prev_frame = 0, prev_irdy = 0;
  int   age = 0, cnt_done = 0, fall_age = 0, wr_idx = 0, rd_idx = 0;
  bit   done_seen = 0;
  logic [1:0] seen_status;
  logic [LEN_W-1:0] seen_count;

  initial begin : target_loop
    forever begin
      @(negedge clk);
      if (pend_xfer) begin
        cnt_done++;
        pend_xfer = 0;
      end
      if (!in_txn) begin
        bus_devsel = 0; bus_trdy = 0; bus_stop = 0;
        if (bus_frame) begin
          // R2: idle cycle before framing; R1: address phase contents
          chk(!prev_frame && !prev_irdy, "R2", "idle before frame", {prev_frame, prev_irdy}, 0);
          chk(bus_ad_out == t_addr && bus_ad_oe, "R1", "address", bus_ad_out, t_addr);
          chk(bus_cbe == (t_write ? 4'h7 : 4'h6) && !bus_irdy, "R1", "command",
              {bus_irdy, bus_cbe}, t_write ? 4'h7 : 4'h6);
          in_txn = 1; age = 0; stop_active = 0; fall_age = 0; cnt_done = 0;
        end
      end else begin
        age++;
        if (!bus_frame && fall_age == 0) fall_age = age;
        if (!bus_frame && !bus_irdy) begin
          in_txn = 0;
          bus_devsel = 0; bus_trdy = 0; bus_stop = 0;
        end else begin
          bus_devsel = t_claim && (age >= t_dly);
          if (stop_active) begin
            bus_trdy = 0;
            bus_stop = 1;
          end else begin
            bus_trdy = bus_devsel && bus_irdy && ($urandom % 4 != 0);
            bus_stop = bus_trdy && (t_stopk != 0) && (cnt_done + 1 == t_stopk);
            if (bus_stop) stop_active = 1;
            if (bus_trdy) begin
              pend_xfer = 1;
              if (t_write) begin
                wlog[cnt_done]   = bus_ad_out;
                wlogbe[cnt_done] = bus_cbe;
              end else begin
                bus_ad_in = rpat(t_addr, cnt_done);
                // R3: read byte enables in data phase
                chk(bus_cbe == t_be && !bus_ad_oe, "R3", "read byte enables", bus_cbe, t_be);
              end
            end
          end
        end
      end
      req_valid = req_go;
      wr_valid  = t_write && (wr_idx < t_len) && ($urandom % 4 != 0);
      wr_data   = wq[wr_idx % MAXB];
      wr_be     = wbe[wr_idx % MAXB];
      rd_ready  = ($urandom % 4 != 0);
      #2;
      if (req_valid && req_ready) req_go = 0;
      if (wr_valid && wr_ready) wr_idx++;
      if (rd_valid && rd_ready) begin
        if (exp_abort) chk(rd_data == 32'hFFFF_FFFF, "R8", "abort read word", rd_data, 32'hFFFF_FFFF);
        else chk(rd_data == rpat(t_addr, rd_idx), "R6", "read word", rd_data, rpat(t_addr, rd_idx));
        rd_idx++;
      end
      if (done_valid) begin
        done_seen   = 1;
        seen_status = done_status;
        seen_count  = done_count;
      end
      prev_frame = bus_frame;
      prev_irdy  = bus_irdy;
    end
  end

  task automatic run_txn(input bit wr, input int len, input bit claim, input int dly,
                         input int stopk);
    int exp_st, exp_cnt, exp_rd;
    t_write = wr; t_len = len; t_claim = claim; t_dly = dly; t_stopk = stopk;
    t_addr  = {$urandom} & 32'hFFFF_FFFC;
    t_be    = 4'($urandom);
    for (int i = 0; i < MAXB; i++) begin
      wq[i] = $urandom; wbe[i] = 4'($urandom);
    end
    exp_abort = !claim;
    if (!claim) begin exp_st = 2; exp_cnt = 0; end
    else if (stopk != 0 && stopk < len) begin exp_st = 1; exp_cnt = stopk; end
    else begin exp_st = 0; exp_cnt = len; end
    exp_rd = wr ? 0 : (claim ? exp_cnt : 1);
    req_write = wr; req_addr = t_addr; req_len = LEN_W'(len); req_be = t_be;
    wr_idx = 0; rd_idx = 0; done_seen = 0;
    req_go = 1;
    for (int w = 0; w < 600 && !done_seen; w++) @(negedge clk);
    #3;
    chk(done_seen, "R4", "done pulse seen", done_seen, 1);
    chk(seen_status == 2'(exp_st), exp_st == 2 ? "R7" : (exp_st == 1 ? "R9" : "R4"),
        "status", seen_status, exp_st);
    chk(seen_count == LEN_W'(exp_cnt), exp_st == 1 ? "R9" : "R4", "count", seen_count, exp_cnt);
    for (int w = 0; w < 60 && rd_idx < exp_rd; w++) @(negedge clk);
    #3;
    if (!wr) chk(rd_idx == exp_rd, exp_abort ? "R8" : "R6", "read words", rd_idx, exp_rd);
    if (wr && done_seen && seen_count == LEN_W'(exp_cnt)) begin
      for (int i = 0; i < exp_cnt; i++) begin
        chk(wlog[i] == wq[i], "R5", "write word", wlog[i], wq[i]);
        chk(wlogbe[i] == wbe[i], "R5", "write byte enables", wlogbe[i], wbe[i]);
      end
    end
    if (!claim && len >= 2)
      chk(fall_age == ABORTC + 1, "R7", "frame drop cycle", fall_age, ABORTC + 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: timeout got %h exp %h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    // R10 reset state
    chk(!bus_frame && !bus_irdy && !bus_ad_oe && !bus_cbe_oe, "R10", "bus idle after reset",
        {bus_frame, bus_irdy, bus_ad_oe, bus_cbe_oe}, 0);
    chk(req_ready && !rd_valid && !done_valid, "R10", "local side after reset",
        {req_ready, rd_valid, done_valid}, 3'b100);
    // directed corners
    run_txn(0, 1, 1, 1, 0);    // R4 single read
    run_txn(1, 1, 1, 1, 0);    // R4 single write
    run_txn(1, 16, 1, 2, 0);   // R5 longest write burst
    run_txn(0, 16, 1, 3, 0);   // R6 longest read burst
    run_txn(1, 4, 0, 1, 0);    // R7 write abort
    run_txn(0, 3, 0, 1, 0);    // R7 R8 read abort
    run_txn(0, 1, 0, 1, 0);    // R8 single read abort
    run_txn(1, 5, 1, 4, 0);    // R7 claim at last allowed cycle
    run_txn(1, 6, 1, 1, 2);    // R9 write disconnect
    run_txn(0, 6, 1, 2, 3);    // R9 read disconnect
    run_txn(1, 4, 1, 1, 1);    // R9 disconnect on first word
    // constrained random
    for (int n = 0; n < 30; n++) begin
      int len, sk;
      len = 1 + ($urandom % MAXB);
      sk  = (len > 1 && ($urandom % 3 == 0)) ? 1 + ($urandom % (len - 1)) : 0;
      run_txn($urandom % 2, len, ($urandom % 8 != 0), 1 + ($urandom % 4), sk);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule